// File: doc/BRIEF.md
# ECC Error Capture Registers

This block sits beside a memory controller's ECC checker and records the errors it reports. Each cycle the checker may raise a correctable-error pulse, an uncorrectable-error pulse, or both. Along with the pulses it presents the failing byte address, the ECC syndrome and the channel the access used. The block turns these pulses into sticky flags and keeps one set of capture registers: the block address (4 KiB granularity), the syndrome and the channel.

Software sees the flags and the captured data through a small register port. A read strobe with a byte offset returns the register one cycle later. A write to the status offset clears flags, one flag for each data bit written as one. Captured information has a priority. An uncorrectable error replaces the data of a pending correctable error. A correctable error never replaces anything that is pending. The first uncorrectable error is kept until software clears it.

Top module: `ecc_err_log`

## Requirements
- R1: After reset both flags are clear, the capture registers hold zero, and every register reads as zero.
- R2: A correctable pulse sets bit 0, and an uncorrectable pulse sets bit 7, of the 16-bit status register at offset 0x00. All other status bits read as zero.
- R3: A write to offset 0x00 clears bit 0 and/or bit 7 where the write data has a one in that position. Zero data bits leave their flag unchanged. Writes to any other offset have no effect.
- R4: The address register at offset 0x04 returns the captured address bits 31:12 in place, with bits 11:0 reading as zero.
- R5: The syndrome register at offset 0x08 returns the captured 8-bit syndrome in bits 7:0. The channel register at offset 0x0C returns the captured channel in bit 0. Unused bits and unmapped offsets read as zero.
- R6: An uncorrectable pulse while only a correctable error is pending overwrites address, syndrome and channel, and both flags then read as set.
- R7: A correctable pulse while a correctable or an uncorrectable error is pending leaves address, syndrome and channel unchanged.
- R8: An uncorrectable pulse while an uncorrectable error is pending keeps the first one's captured information.
- R9: Once the relevant flags are cleared, the next error loads the capture registers again.
- R10: Read data appears in the cycle after the read strobe and holds its value while no strobe is given.
- R11: An error pulse in the same cycle as a write that clears its flag leaves the flag set, and that error's information is captured.
- R12: Correctable and uncorrectable pulses in the same cycle with nothing pending set both flags and capture the presented information.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_pulse_i | input | 1 | Correctable error reported this cycle |
| ue_pulse_i | input | 1 | Uncorrectable error reported this cycle |
| err_addr_i | input | ADDR_W (32) | Failing byte address |
| err_syn_i | input | SYN_W (8) | ECC syndrome |
| err_chan_i | input | CHAN_W (1) | Channel of the failing access |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_off_i | input | OFF_W (8) | Byte offset of the register |
| reg_wdata_i | input | 16 | Write data, ones clear status flags |
| reg_rdata_o | output | ADDR_W (32) | Read data, valid the cycle after a strobe |

## Verification
The bench builds the block with its defaults: a 32-bit address, an 8-bit syndrome and two channels. With these values the 20-bit block field, the zeroed low 12 bits, and both channel values can all be seen on the read port. Directed sequences cover the cases where pulses fight over the capture registers: a UE over a CE, a CE over either, a UE over a UE, two pulses in one cycle, and a pulse coinciding with a clearing write.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_STATUS = 8'h00;
  localparam logic [OFF_W-1:0] OFF_ADDR   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_SYN    = 8'h08;
  localparam logic [OFF_W-1:0] OFF_CHAN   = 8'h0C;
  localparam int STAT_W = 16;
  localparam int CE_BIT = 0;
  localparam int UE_BIT = 7;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_pulse_i,
  input  logic ue_pulse_i,
  input  logic clr_ce_i,
  input  logic clr_ue_i,
  output logic ce_q_o,
  output logic ue_q_o,
  output logic ce_free_o,
  output logic ue_free_o
);
  logic ce_keep, ue_keep;

  assign ce_keep   = ce_q_o & ~clr_ce_i;
  assign ue_keep   = ue_q_o & ~clr_ue_i;
  assign ce_free_o = ~ce_keep;
  assign ue_free_o = ~ue_keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q_o <= 1'b0;
      ue_q_o <= 1'b0;
    end else begin
      ce_q_o <= ce_keep | ce_pulse_i;  // new error beats clear
      ue_q_o <= ue_keep | ue_pulse_i;
    end
  end

  p_ce_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_pulse_i |=> ce_q_o);
  p_ue_sets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_pulse_i && clr_ue_i) |=> ue_q_o);
  p_ce_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ce_i && !ce_pulse_i) |=> !ce_q_o);
  p_ue_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ue_pulse_i && !clr_ue_i) |=> $stable(ue_q_o));
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int BLK_W  = 20,
  parameter int SYN_W  = 8,
  parameter int CHAN_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_pulse_i,
  input  logic              ue_pulse_i,
  input  logic              ce_free_i,
  input  logic              ue_free_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [BLK_W-1:0]  blk_q_o,
  output logic [SYN_W-1:0]  syn_q_o,
  output logic [CHAN_W-1:0] chan_q_o
);
  logic load;

  // UE may overwrite pending CE data; CE only fills an empty slot
  assign load = ue_free_i & (ue_pulse_i | (ce_pulse_i & ce_free_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q_o  <= '0;
      syn_q_o  <= '0;
      chan_q_o <= '0;
    end else if (load) begin
      blk_q_o  <= blk_i;
      syn_q_o  <= syn_i;
      chan_q_o <= chan_i;
    end
  end

  p_ue_over_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_pulse_i && ue_free_i) |=> (blk_q_o == $past(blk_i)) && (syn_q_o == $past(syn_i)));
  p_ce_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_pulse_i && !ue_pulse_i && !(ce_free_i && ue_free_i)) |=> $stable(blk_q_o) && $stable(syn_q_o));
  p_ue_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_pulse_i && !ue_free_i) |=> $stable(blk_q_o) && $stable(chan_q_o));
endmodule

// File: rtl/ecc_log_rdport.sv
module ecc_log_rdport
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SYN_W      = 8,
  parameter int CHAN_W     = 1,
  localparam int BLK_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              ce_q_i,
  input  logic              ue_q_i,
  input  logic [BLK_W-1:0]  blk_q_i,
  input  logic [SYN_W-1:0]  syn_q_i,
  input  logic [CHAN_W-1:0] chan_q_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] rd_mux;
  logic [STAT_W-1:0] stat_word;

  always_comb begin
    stat_word         = '0;
    stat_word[CE_BIT] = ce_q_i;
    stat_word[UE_BIT] = ue_q_i;
    case (off_i)
      OFF_STATUS: rd_mux = ADDR_W'(stat_word);
      OFF_ADDR:   rd_mux = {blk_q_i, {PAGE_SHIFT{1'b0}}};
      OFF_SYN:    rd_mux = ADDR_W'(syn_q_i);
      OFF_CHAN:   rd_mux = ADDR_W'(chan_q_i);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_addr_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && off_i == OFF_ADDR) |=> rdata_o[PAGE_SHIFT-1:0] == '0);
  p_stat_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && off_i == OFF_STATUS) |=> $countones(rdata_o) <= 2);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SYN_W      = 8,
  parameter int NUM_CHAN   = 2,
  localparam int CHAN_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int BLK_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_pulse_i,
  input  logic              ue_pulse_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic [CHAN_W-1:0] err_chan_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [OFF_W-1:0]  reg_off_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o
);
  logic stat_wr, clr_ce, clr_ue;
  logic ce_q, ue_q, ce_free, ue_free;
  logic [BLK_W-1:0]  blk_q;
  logic [SYN_W-1:0]  syn_q;
  logic [CHAN_W-1:0] chan_q;
  logic unused_bits;

  assign stat_wr = reg_wr_i && (reg_off_i == OFF_STATUS);
  assign clr_ce  = stat_wr & reg_wdata_i[CE_BIT];
  assign clr_ue  = stat_wr & reg_wdata_i[UE_BIT];
  assign unused_bits = ^{reg_wdata_i, err_addr_i[PAGE_SHIFT-1:0]};

  ecc_log_status u_status (
    .clk_i, .rst_ni, .ce_pulse_i, .ue_pulse_i,
    .clr_ce_i (clr_ce),  .clr_ue_i (clr_ue),
    .ce_q_o   (ce_q),    .ue_q_o   (ue_q),
    .ce_free_o(ce_free), .ue_free_o(ue_free)
  );

  ecc_log_capture #(.BLK_W(BLK_W), .SYN_W(SYN_W), .CHAN_W(CHAN_W)) u_capture (
    .clk_i, .rst_ni, .ce_pulse_i, .ue_pulse_i,
    .ce_free_i(ce_free), .ue_free_i(ue_free),
    .blk_i    (err_addr_i[ADDR_W-1:PAGE_SHIFT]),
    .syn_i    (err_syn_i), .chan_i(err_chan_i),
    .blk_q_o  (blk_q), .syn_q_o(syn_q), .chan_q_o(chan_q)
  );

  ecc_log_rdport #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SYN_W(SYN_W),
                   .CHAN_W(CHAN_W)) u_rdport (
    .clk_i, .rst_ni, .rd_i(reg_rd_i), .off_i(reg_off_i),
    .ce_q_i(ce_q), .ue_q_i(ue_q), .blk_q_i(blk_q), .syn_q_i(syn_q),
    .chan_q_i(chan_q), .rdata_o(reg_rdata_o)
  );

  p_wr_other_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_off_i != OFF_STATUS && !ce_pulse_i && ce_q) |=> ce_q);
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ce_p = 0, ue_p = 0;
  logic [31:0] addr = 0;
  logic [7:0]  syn = 0;
  logic [0:0]  chan = 0;
  logic        rd = 0, wr = 0;
  logic [7:0]  off = 0;
  logic [15:0] wdata = 0;
  logic [31:0] rdata;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  ecc_err_log u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_pulse_i(ce_p), .ue_pulse_i(ue_p),
    .err_addr_i(addr), .err_syn_i(syn), .err_chan_i(chan),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_off_i(off), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic rd_reg(logic [7:0] o, output logic [31:0] v);
    @(negedge clk); rd = 1; off = o;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] o, logic [31:0] exp);
    logic [31:0] v;
    rd_reg(o, v);
    chk(req, v, exp);
  endtask

  task automatic err(logic c, logic u, logic [31:0] a, logic [7:0] s, logic ch);
    @(negedge clk); ce_p = c; ue_p = u; addr = a; syn = s; chan = ch;
    @(negedge clk); ce_p = 0; ue_p = 0;
  endtask

  task automatic wr_reg(logic [7:0] o, logic [15:0] d);
    @(negedge clk); wr = 1; off = o; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 8'h00, 0);
    rd_chk("R1 addr",   8'h04, 0);
    rd_chk("R1 syn",    8'h08, 0);
    rd_chk("R1 chan",   8'h0C, 0);
  endtask

  task automatic t_ce_basic;
    err(1, 0, 32'h1234_5ABC, 8'h5A, 1);
    rd_chk("R2 ce flag", 8'h00, 32'h0001);
    rd_chk("R4 addr",    8'h04, 32'h1234_5000);
    rd_chk("R5 syn",     8'h08, 32'h0000_005A);
    rd_chk("R5 chan",    8'h0C, 32'h0000_0001);
    rd_chk("R5 unmapped", 8'h10, 0);
    wr_reg(8'h04, 16'hFFFF);
    rd_chk("R3 other offset ignored", 8'h00, 32'h0001);
    wr_reg(8'h00, 16'h007E);
    rd_chk("R3 zero bits ignored", 8'h00, 32'h0001);
    wr_reg(8'h00, 16'h0001);
    rd_chk("R3 ce cleared", 8'h00, 0);
  endtask

  task automatic t_priority;
    err(1, 0, 32'hAAAA_1000, 8'h11, 1);
    err(0, 1, 32'hBBBB_2FFF, 8'h22, 0);
    rd_chk("R6 both flags", 8'h00, 32'h0081);
    rd_chk("R6 ue addr",    8'h04, 32'hBBBB_2000);
    rd_chk("R6 ue syn",     8'h08, 32'h22);
    rd_chk("R6 ue chan",    8'h0C, 0);
    err(1, 0, 32'hCCCC_3000, 8'h33, 1);
    rd_chk("R7 ce no overwrite", 8'h04, 32'hBBBB_2000);
    rd_chk("R7 ce syn kept",     8'h08, 32'h22);
    err(0, 1, 32'hDDDD_4000, 8'h44, 1);
    rd_chk("R8 first ue kept", 8'h04, 32'hBBBB_2000);
    rd_chk("R8 chan kept",     8'h0C, 0);
    wr_reg(8'h00, 16'h0080);
    rd_chk("R3 ue only cleared", 8'h00, 32'h0001);
    err(1, 0, 32'hEEEE_5000, 8'h55, 1);
    rd_chk("R7 ce pending blocks", 8'h04, 32'hBBBB_2000);
    wr_reg(8'h00, 16'h0081);
    rd_chk("R3 all cleared", 8'h00, 0);
  endtask

  task automatic t_reload;
    err(1, 0, 32'h0F0F_6123, 8'h66, 1);
    rd_chk("R9 reload addr", 8'h04, 32'h0F0F_6000);
    rd_chk("R9 reload syn",  8'h08, 32'h66);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr = 1; off = 8'h00; wdata = 16'h0001;
    ce_p = 1; addr = 32'h7777_7000; syn = 8'h77; chan = 0;
    @(negedge clk); wr = 0; ce_p = 0;
    rd_chk("R11 flag survives clear", 8'h00, 32'h0001);
    rd_chk("R11 new info captured",   8'h04, 32'h7777_7000);
    rd_chk("R11 new chan",            8'h0C, 0);
    wr_reg(8'h00, 16'h0081);
  endtask

  task automatic t_both;
    err(1, 1, 32'h8888_8000, 8'h88, 1);
    rd_chk("R12 both flags", 8'h00, 32'h0081);
    rd_chk("R12 addr",       8'h04, 32'h8888_8000);
    rd_chk("R12 syn",        8'h08, 32'h88);
  endtask

  task automatic t_rd_timing;
    logic [31:0] v;
    wr_reg(8'h00, 16'h0081);
    @(negedge clk); rd = 1; off = 8'h00;
    @(negedge clk); rd = 0;
    chk("R10 data after strobe", rdata, 0);
    err(0, 1, 32'h9999_9000, 8'h99, 0);
    chk("R10 holds without strobe", rdata, 0);
    rd_reg(8'h00, v);
    chk("R10 fresh read", v, 32'h0080);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ce_basic;
    t_priority;
    t_reload;
    t_same_cycle;
    t_both;
    t_rd_timing;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule